// File: doc/BRIEF.md
# Three-Channel Fixed-Mode Interval Timer

This block holds three 16-bit down-counters that all advance on a shared timer clock enable. The counting behaviour of each channel is fixed in hardware. Channel 0 is a periodic tick generator. Channel 1 is a one-shot delay flag. Channel 2 is a square-wave generator. Firmware reaches the block through a byte-wide register port. There is one control offset and one data offset per channel.

To start a channel, firmware writes a control byte that names the channel and asks for a load. It then writes the low byte and the high byte of the count to that channel's data offset. Firmware can also snapshot a running count with a latch control byte and read it back as two bytes. Only two control fields carry meaning: the channel field and the access field. Mode selection, BCD counting and gating are not part of this block.

Top module: `itimer_top`

## Requirements
- R1: After reset, out_tick is high, out_delay is low and out_square is high, and a two-byte read of any channel returns 0.
- R2: A control write at offset 0xE sets the channel with bits 7:6 (0, 1 or 2) and requests a load with bits 5:4 = 11. The write halts that channel and puts its output at its idle level (high for channels 0 and 2, low for channel 1). The next two data writes to the channel's offset (0x8, 0xA or 0xC) are taken as the low byte and then the high byte. The high-byte write sets the live count to the loaded value N, and counting starts on the first enabled tick after it.
- R3: Channel 0 is low for exactly one tick interval, while its live count is 1. It is high otherwise, and it reloads N on the next tick, so the period is N ticks. N must be at least 2.
- R4: After its high-byte write, channel 1 stays low for N ticks and then goes high. It stays high while the counter keeps counting and wrapping, until the next load control byte for channel 1.
- R5: Channel 2 has a period of N ticks. It is high for ceil(N/2) ticks and then low for floor(N/2) ticks, and it reloads automatically. The live count steps N, N-1, ..., 1.
- R6: A loaded count of 0 acts as 65536 for all three channels.
- R7: Counters and outputs move only on cycles where tick_en is high. Register writes are the only other thing that can change an output.
- R8: A control byte with bits 5:4 = 00 (0x00, 0x40 or 0x80) latches the channel's current count. Counting goes on. A second latch command while a latched value is still unread is ignored.
- R9: Each channel port has a byte toggle. Reads return the low byte first and then the high byte. They return the latched value while a latch is held, and otherwise the live count. Reading the high byte releases the latch. A read at the control offset returns 0.
- R10: The following writes have no effect on any channel: a control byte with bits 7:6 = 11, a control byte with bits 5:4 = 01 or 10, and a data write to a channel with no load pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared timer clock enable; each high cycle is one count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; advances the addressed channel's byte toggle |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for the addressed offset (combinational) |
| out_tick | output | 1 | Channel 0 periodic tick, low-active pulse |
| out_delay | output | 1 | Channel 1 one-shot flag |
| out_square | output | 1 | Channel 2 square wave |

## Verification
A wrong count or reload value in channel 0 or 2 moves the output edges. This shows up at the ports within one period, because the bench compares all three outputs against its own model on every clock. A wrong one-shot state shows up either as an early or late rise of out_delay, or as a drop while it should hold. Latch and toggle faults are invisible at the outputs, so the bench reads counts back. A lost or re-taken snapshot, or a toggle out of step, then gives a wrong byte on the very next read.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NUM_CH  = 3;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 2;

    localparam logic [ADDR_W-1:0] CTL_OFF   = 4'hE;
    localparam logic [ADDR_W-1:0] DATA_BASE = 4'h8;

    localparam logic [1:0] ACC_LATCH = 2'b00;
    localparam logic [1:0] ACC_LOAD  = 2'b11;

    typedef enum logic [1:0] {
        MODE_RATE    = 2'd0,
        MODE_ONESHOT = 2'd1,
        MODE_SQUARE  = 2'd2
    } chan_mode_e;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_LOW  = 2'd1,
        LD_HIGH = 2'd2
    } ld_phase_e;

    typedef struct packed {
        logic load_ctl;
        logic latch_ctl;
        logic data_wr;
        logic data_rd;
    } chan_strobe_t;

    function automatic logic [ADDR_W-1:0] data_off(input int ch);
        return DATA_BASE + ADDR_W'(2 * ch);
    endfunction

    function automatic chan_mode_e mode_of(input int ch);
        case (ch)
            0:       return MODE_RATE;
            1:       return MODE_ONESHOT;
            default: return MODE_SQUARE;
        endcase
    endfunction

    // count value 0 stands for the full range
    function automatic logic [CNT_W:0] full_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, c};
    endfunction

endpackage

// File: rtl/itimer_regif.sv
module itimer_regif
    import itimer_pkg::*;
(
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [SEL_W-1:0]           ctl_sel,
    input  logic [1:0]                 ctl_acc,
    output chan_strobe_t [NUM_CH-1:0]  stb
);

    logic ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == CTL_OFF);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            stb[i].load_ctl  = ctl_wr && (ctl_sel == SEL_W'(i)) && (ctl_acc == ACC_LOAD);
            stb[i].latch_ctl = ctl_wr && (ctl_sel == SEL_W'(i)) && (ctl_acc == ACC_LATCH);
            stb[i].data_wr   = reg_wr && (reg_addr == data_off(i));
            stb[i].data_rd   = reg_rd && (reg_addr == data_off(i));
        end
    end

endmodule

// File: rtl/itimer_channel.sv
module itimer_channel
    import itimer_pkg::*;
#(
    parameter chan_mode_e MODE = MODE_RATE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  chan_strobe_t      stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              wave
);

    ld_phase_e          ld_q;
    logic [BYTE_W-1:0]  lo_q;
    logic [CNT_W-1:0]   reload_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   snap_q;
    logic               armed_q;
    logic               snap_vld_q;
    logic               rd_hi_q;
    logic               done_q;

    logic               hi_wr;
    logic               lo_wr;
    logic [CNT_W-1:0]   next_cnt;
    logic [CNT_W-1:0]   view;
    logic [CNT_W-1:0]   new_count;

    assign lo_wr     = stb.data_wr && (ld_q == LD_LOW);
    assign hi_wr     = stb.data_wr && (ld_q == LD_HIGH);
    assign new_count = {wdata, lo_q};

    always_comb begin
        if (MODE == MODE_ONESHOT)
            next_cnt = cnt_q - 1'b1;
        else if (cnt_q == CNT_W'(1))
            next_cnt = reload_q;
        else
            next_cnt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q       <= LD_IDLE;
            lo_q       <= '0;
            reload_q   <= '0;
            cnt_q      <= '0;
            snap_q     <= '0;
            armed_q    <= 1'b0;
            snap_vld_q <= 1'b0;
            rd_hi_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (stb.load_ctl) begin
                ld_q       <= LD_LOW;
                armed_q    <= 1'b0;
                done_q     <= 1'b0;
                snap_vld_q <= 1'b0;
                rd_hi_q    <= 1'b0;
            end else if (lo_wr) begin
                lo_q <= wdata;
                ld_q <= LD_HIGH;
            end else if (hi_wr) begin
                reload_q <= new_count;
                cnt_q    <= new_count;
                armed_q  <= 1'b1;
                done_q   <= 1'b0;
                ld_q     <= LD_IDLE;
            end else if (tick && armed_q) begin
                cnt_q <= next_cnt;
                if (MODE == MODE_ONESHOT && cnt_q == CNT_W'(1))
                    done_q <= 1'b1;
            end

            if (stb.latch_ctl && !snap_vld_q) begin
                snap_q     <= cnt_q;
                snap_vld_q <= 1'b1;
            end

            if (stb.data_rd) begin
                rd_hi_q <= !rd_hi_q;
                if (rd_hi_q)
                    snap_vld_q <= 1'b0;
            end
        end
    end

    assign view  = snap_vld_q ? snap_q : cnt_q;
    assign rdata = rd_hi_q ? view[CNT_W-1:BYTE_W] : view[BYTE_W-1:0];

    always_comb begin
        case (MODE)
            MODE_RATE:    wave = !(armed_q && cnt_q == CNT_W'(1));
            MODE_ONESHOT: wave = done_q;
            default:      wave = !armed_q ||
                                 (full_count(cnt_q) > (full_count(reload_q) >> 1));
        endcase
    end

endmodule

// File: rtl/itimer_top.sv
module itimer_top
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              out_tick,
    output logic              out_delay,
    output logic              out_square
);

    chan_strobe_t [NUM_CH-1:0]             stb;
    logic [NUM_CH-1:0][BYTE_W-1:0]         ch_rdata;
    logic [NUM_CH-1:0]                     ch_wave;

    itimer_regif u_regif (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .ctl_sel  (reg_wdata[7:6]),
        .ctl_acc  (reg_wdata[5:4]),
        .stb      (stb)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        itimer_channel #(
            .MODE (mode_of(g))
        ) u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick_en),
            .stb   (stb[g]),
            .wdata (reg_wdata),
            .rdata (ch_rdata[g]),
            .wave  (ch_wave[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == data_off(i))
                reg_rdata = ch_rdata[i];
        end
    end

    assign out_tick   = ch_wave[0];
    assign out_delay  = ch_wave[1];
    assign out_square = ch_wave[2];

endmodule

// File: rtl/itimer_checks.sv
module itimer_checks
    import itimer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       out_tick,
    input logic       out_delay,
    input logic       out_square
);

    logic ctl_wr;
    assign ctl_wr = reg_wr && (reg_addr == CTL_OFF);

    a_r2_ch0_halts: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[7:6] == 2'd0 && reg_wdata[5:4] == 2'b11) |=> out_tick);

    a_r2_ch1_halts: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[7:6] == 2'd1 && reg_wdata[5:4] == 2'b11) |=> !out_delay);

    a_r2_ch2_halts: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && reg_wdata[7:6] == 2'd2 && reg_wdata[5:4] == 2'b11) |=> out_square);

    a_r4_delay_holds: assert property (@(posedge clk) disable iff (rst)
        (out_delay && !(ctl_wr && reg_wdata[7:6] == 2'd1 && reg_wdata[5:4] == 2'b11))
        |=> out_delay);

    a_r7_still_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !reg_wr) |=> $stable({out_tick, out_delay, out_square}));

    a_r10_bad_channel: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && ctl_wr && reg_wdata[7:6] == 2'd3)
        |=> $stable({out_tick, out_delay, out_square}));

    a_r9_ctl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == CTL_OFF) |-> (reg_rdata == 8'h00));

endmodule

bind itimer_top itimer_checks u_chk (.*);

// File: tb/itimer_top_bench.sv
module itimer_top_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       out_tick, out_delay, out_square;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_armed [3];
    int m_n     [3];
    int m_ph    [3];
    int m_ld    [3];
    int m_lo    [3];
    int m_snapv [3];
    int m_snap  [3];
    int m_rdhi  [3];
    int m_froz  [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    itimer_top u_itimer_top (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_tick(out_tick), .out_delay(out_delay), .out_square(out_square)
    );

    function automatic int live(int c);
        if (m_armed[c] == 0) return m_froz[c];
        if (c == 1) return ((m_n[c] - m_ph[c]) % 65536 + 65536) % 65536;
        return (m_n[c] - (m_ph[c] % m_n[c])) % 65536;
    endfunction

    function automatic int exp_wave(int c);
        if (c == 1) return (m_armed[c] != 0 && m_ph[c] >= m_n[c]) ? 1 : 0;
        if (m_armed[c] == 0) return 1;
        if (c == 0) return ((m_ph[c] % m_n[c]) != m_n[c] - 1) ? 1 : 0;
        return ((m_ph[c] % m_n[c]) < (m_n[c] + 1) / 2) ? 1 : 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_armed[c] = 0; m_n[c] = 1; m_ph[c] = 0; m_ld[c] = 0; m_lo[c] = 0;
            m_snapv[c] = 0; m_snap[c] = 0; m_rdhi[c] = 0; m_froz[c] = 0;
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] d, input logic tk);
        int pre [3];
        int off;
        int v;
        bit ctl;
        @(negedge clk);
        check((cur_req == "R1") ? "R1" : "R3", "out_tick", int'(out_tick), exp_wave(0));
        check((cur_req == "R1") ? "R1" : "R4", "out_delay", int'(out_delay), exp_wave(1));
        check((cur_req == "R1") ? "R1" : "R5", "out_square", int'(out_square), exp_wave(2));
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; tick_en = tk;
        #1;
        for (int c = 0; c < 3; c++) pre[c] = live(c);
        if (rd) begin
            if (a == 4'hE) check("R9", "ctl read", int'(reg_rdata), 0);
            for (int c = 0; c < 3; c++) begin
                if (a == 4'(8 + 2 * c)) begin
                    v = (m_snapv[c] != 0) ? m_snap[c] : pre[c];
                    v = (m_rdhi[c] != 0) ? (v >> 8) : (v & 255);
                    check(cur_req, "read byte", int'(reg_rdata), v);
                end
            end
        end
        ctl = wr && (a == 4'hE);
        for (int c = 0; c < 3; c++) begin
            off = 8 + 2 * c;
            if (ctl && d[7:6] == 2'(c) && d[5:4] == 2'b11) begin
                m_froz[c] = pre[c]; m_armed[c] = 0; m_ld[c] = 1;
                m_snapv[c] = 0; m_rdhi[c] = 0;
            end else if (wr && a == 4'(off) && m_ld[c] == 1) begin
                m_lo[c] = d; m_ld[c] = 2;
            end else if (wr && a == 4'(off) && m_ld[c] == 2) begin
                v = d * 256 + m_lo[c];
                m_n[c] = (v == 0) ? 65536 : v;
                m_armed[c] = 1; m_ph[c] = 0; m_ld[c] = 0;
            end else if (tk && m_armed[c] != 0) begin
                m_ph[c]++;
            end
            if (ctl && d[7:6] == 2'(c) && d[5:4] == 2'b00 && m_snapv[c] == 0) begin
                m_snap[c] = pre[c]; m_snapv[c] = 1;
            end
            if (rd && a == 4'(off)) begin
                if (m_rdhi[c] != 0) m_snapv[c] = 0;
                m_rdhi[c] = 1 - m_rdhi[c];
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1);
    endtask

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        step(1'b1, 1'b0, a, d, 1'b1);
    endtask

    task automatic rd_reg(logic [3:0] a);
        step(1'b0, 1'b1, a, 8'h00, 1'b1);
    endtask

    task automatic load(int c, int n);
        logic [7:0] cw;
        cw = (c == 0) ? 8'h3A : (c == 1) ? 8'h70 : 8'hB6;
        wr_reg(4'hE, cw);
        wr_reg(4'(8 + 2 * c), 8'(n & 255));
        wr_reg(4'(8 + 2 * c), 8'((n >> 8) & 255));
    endtask

    initial begin
        #(CLK_PERIOD * 195000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle levels and zero readback after reset
        cur_req = "R1";
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b0);
        rd_reg(4'h8); rd_reg(4'h8);
        rd_reg(4'hC); rd_reg(4'hC);
        rd_reg(4'hE);

        // R3 rate generator, R5 square (odd and even), R4 one-shot
        cur_req = "R3";
        load(0, 5);
        idle(30);
        cur_req = "R5";
        load(2, 7);
        idle(40);
        load(2, 6);
        idle(30);
        cur_req = "R4";
        load(1, 20);
        idle(40);

        // R7: counting only on enabled ticks
        cur_req = "R7";
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0, 4'h0, 8'h00, (i % 3) == 0);
        rd_reg(4'hC); rd_reg(4'hC);

        // R8/R9: latch, hold while counting, release after high byte
        cur_req = "R8";
        wr_reg(4'hE, 8'h00);
        idle(3);
        rd_reg(4'h8); rd_reg(4'h8);
        cur_req = "R9";
        idle(2);
        rd_reg(4'h8); idle(1); rd_reg(4'h8);
        cur_req = "R8";
        wr_reg(4'hE, 8'h80);
        idle(2);
        wr_reg(4'hE, 8'h80);
        idle(2);
        rd_reg(4'hC); rd_reg(4'hC);
        rd_reg(4'hC); rd_reg(4'hC);

        // R10: meaningless control and stray data writes
        cur_req = "R10";
        wr_reg(4'hE, 8'hF6);
        wr_reg(4'hE, 8'h16);
        wr_reg(4'hE, 8'h60);
        wr_reg(4'hC, 8'h03);
        wr_reg(4'hA, 8'h09);
        step(1'b1, 1'b0, 4'hE, 8'hE6, 1'b0);
        idle(12);
        rd_reg(4'h8); rd_reg(4'h8);
        rd_reg(4'hA); rd_reg(4'hA);

        // R2: halted between control byte and high byte
        cur_req = "R2";
        wr_reg(4'hE, 8'h3A);
        idle(5);
        wr_reg(4'h8, 8'h04);
        idle(3);
        wr_reg(4'h8, 8'h00);
        idle(12);
        rd_reg(4'h8); rd_reg(4'h8);

        // R6: zero count acts as 65536
        cur_req = "R6";
        load(0, 0);
        load(1, 0);
        rd_reg(4'hA); rd_reg(4'hA);
        idle(65545);
        rd_reg(4'h8); rd_reg(4'h8);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule